// File: doc/BRIEF.md
# Bidirectional Registered Latching Bus Transceiver

This block moves a data word between two buses, called A and B, in both directions at once. Each direction owns one storage word that works in one of three ways. It can be transparent, so the destination follows the source. It can hold a value that was latched. It can be loaded on a rising edge of that direction's strobe. Each direction also has its own output enable, active low. The enable only controls whether the destination port drives; it never touches the stored word. The two directions share no state.

Every bus pin is modelled as three separate signals: a data input, a data output and a drive flag. This keeps the block synthesizable. Everything runs on one system clock. The per-direction strobes are level inputs that the block samples on that clock, and a strobe "rising edge" means a clock edge where the strobe is seen high after being seen low at the edge before. A low-active asynchronous reset clears both stored words. The data width is a parameter, 18 by default.

Top module: `duplex_hold_xcvr`

## Requirements
- R1: While a direction's output enable (`*_oe_n`) is high, that direction's drive flag is 0 and its data output is all zeros, whatever the other controls do.
- R2: While a direction's pass control is high and its output enable is low, the destination data output equals the source data input in the same cycle.
- R3: With pass low and strobe enable (`*_stb_en_n`) low, a strobe rising edge stores the source data present at that clock edge. The stored value appears on the destination output from the cycle that follows.
- R4: With pass low and strobe enable high, strobe rising edges leave the stored value unchanged.
- R5: With pass low and no strobe rising edge, the stored value and the destination output stay constant. This holds while the strobe sits high and while it sits low.
- R6: While pass is high, each clock edge loads the source into storage. After pass falls, the value from the last edge with pass high stays on the output until a qualifying strobe edge.
- R7: The A-to-B direction (source `a_in`, destination `b_out`) and the B-to-A direction (source `b_in`, destination `a_out`) are independent. Activity on one direction's controls never changes the other direction's output.
- R8: Reset clears both stored words to zero. A strobe that is already high when reset is released does not count as a rising edge.
- R9: Turning a direction's output off and back on does not change its stored word.
- R10: The data width is the parameter `W`, which defaults to 18 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | W | Data arriving on the A bus |
| a_out | output | W | Data driven onto the A bus (B-to-A path) |
| a_drive | output | 1 | High when the A bus is driven |
| b_in | input | W | Data arriving on the B bus |
| b_out | output | W | Data driven onto the B bus (A-to-B path) |
| b_drive | output | 1 | High when the B bus is driven |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_pass | input | 1 | A-to-B transparent control |
| ab_stb | input | 1 | A-to-B strobe level |
| ab_stb_en_n | input | 1 | A-to-B strobe enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_pass | input | 1 | B-to-A transparent control |
| ba_stb | input | 1 | B-to-A strobe level |
| ba_stb_en_n | input | 1 | B-to-A strobe enable, active low |

## Verification
The assertions assume that every control and data input changes only between clock edges, so the value sampled at an edge is the value the transparent path shows. The bench drives all inputs one nanosecond after each rising edge and holds them steady until the next edge. The capture assertions use the block's own strobe-edge wires rather than raw strobe history, so a strobe that is high during reset is never read as an edge. The bench deliberately holds both strobes high through reset release to test this.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_PASS    = 2'd1,
    MODE_CAPTURE = 2'd2
  } lane_mode_e;

  localparam int unsigned LANE_COUNT = 2;
  localparam int unsigned LANE_AB    = 0;
  localparam int unsigned LANE_BA    = 1;

  // Pass has priority; an edge stores only when the enable is low.
  function automatic lane_mode_e pick_mode(input logic pass,
                                           input logic rise,
                                           input logic stb_en_n);
    lane_mode_e m;
    if (pass)                m = MODE_PASS;
    else if (rise && !stb_en_n) m = MODE_CAPTURE;
    else                     m = MODE_HOLD;
    return m;
  endfunction

  function automatic logic mode_loads(input lane_mode_e m);
    return (m != MODE_HOLD);
  endfunction

endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  // Reset value high: a strobe held high across reset is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/xcvr_gate.sv
module xcvr_gate #(
  parameter int unsigned W = 18
) (
  input  logic [W-1:0] view,
  input  logic         oe_n,
  output logic [W-1:0] dst,
  output logic         drive
);
  assign drive = ~oe_n;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dst[i] = view[i] & ~oe_n;
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         pass,
  input  logic         stb,
  input  logic         stb_en_n,
  input  logic         oe_n,
  output logic [W-1:0] dst,
  output logic         drive,
  output logic [W-1:0] held_o,
  output logic         rise_o
);
  logic         rise;
  lane_mode_e   mode;
  logic [W-1:0] held_q;
  logic [W-1:0] view;

  xcvr_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (stb),
    .rise  (rise)
  );

  assign mode = pick_mode(pass, rise, stb_en_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               held_q <= '0;
    else if (mode_loads(mode)) held_q <= src;
  end

  assign view = pass ? src : held_q;

  xcvr_gate #(.W(W)) u_gate (
    .view  (view),
    .oe_n  (oe_n),
    .dst   (dst),
    .drive (drive)
  );

  assign held_o = held_q;
  assign rise_o = rise;
endmodule

// File: rtl/duplex_hold_xcvr.sv
module duplex_hold_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  input  logic         ab_oe_n,
  input  logic         ab_pass,
  input  logic         ab_stb,
  input  logic         ab_stb_en_n,
  input  logic         ba_oe_n,
  input  logic         ba_pass,
  input  logic         ba_stb,
  input  logic         ba_stb_en_n
);
  logic [LANE_COUNT-1:0][W-1:0] src_v, dst_v, held_v;
  logic [LANE_COUNT-1:0]        pass_v, stb_v, en_v, oe_v, drv_v, rise_v;

  assign src_v[LANE_AB]  = a_in;
  assign src_v[LANE_BA]  = b_in;
  assign pass_v[LANE_AB] = ab_pass;
  assign pass_v[LANE_BA] = ba_pass;
  assign stb_v[LANE_AB]  = ab_stb;
  assign stb_v[LANE_BA]  = ba_stb;
  assign en_v[LANE_AB]   = ab_stb_en_n;
  assign en_v[LANE_BA]   = ba_stb_en_n;
  assign oe_v[LANE_AB]   = ab_oe_n;
  assign oe_v[LANE_BA]   = ba_oe_n;

  for (genvar d = 0; d < LANE_COUNT; d++) begin : g_lane
    xcvr_lane #(.W(W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (src_v[d]),
      .pass     (pass_v[d]),
      .stb      (stb_v[d]),
      .stb_en_n (en_v[d]),
      .oe_n     (oe_v[d]),
      .dst      (dst_v[d]),
      .drive    (drv_v[d]),
      .held_o   (held_v[d]),
      .rise_o   (rise_v[d])
    );
  end

  assign b_out   = dst_v[LANE_AB];
  assign b_drive = drv_v[LANE_AB];
  assign a_out   = dst_v[LANE_BA];
  assign a_drive = drv_v[LANE_BA];

  // Named internal events for the checker.
  logic [W-1:0] ab_held, ba_held;
  logic         ab_rise, ba_rise;
  assign ab_held = held_v[LANE_AB];
  assign ba_held = held_v[LANE_BA];
  assign ab_rise = rise_v[LANE_AB];
  assign ba_rise = rise_v[LANE_BA];
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_drive,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_drive,
  input logic         ab_oe_n,
  input logic         ab_pass,
  input logic         ab_stb_en_n,
  input logic         ba_oe_n,
  input logic         ba_pass,
  input logic         ba_stb_en_n,
  input logic [W-1:0] ab_held,
  input logic [W-1:0] ba_held,
  input logic         ab_rise,
  input logic         ba_rise
);
  AST_AB_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ab_oe_n |-> (!b_drive && b_out == '0)); // R1
  AST_BA_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ba_oe_n |-> (!a_drive && a_out == '0)); // R1
  AST_AB_PASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_oe_n && ab_pass) |-> (b_out == a_in)); // R2
  AST_BA_PASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_oe_n && ba_pass) |-> (a_out == b_in)); // R2
  AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_pass && !ab_stb_en_n && ab_rise) |=> (ab_held == $past(a_in))); // R3
  AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_pass && !ba_stb_en_n && ba_rise) |=> (ba_held == $past(b_in))); // R3
  AST_AB_EN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_pass && ab_stb_en_n) |=> $stable(ab_held)); // R4
  AST_BA_EN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_pass && ba_stb_en_n) |=> $stable(ba_held)); // R4
  AST_AB_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_pass && !ab_rise) |=> $stable(ab_held)); // R5
  AST_BA_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_pass && !ba_rise) |=> $stable(ba_held)); // R5
  AST_AB_PASS_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ab_pass |=> (ab_held == $past(a_in))); // R6
  AST_BA_PASS_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ba_pass |=> (ba_held == $past(b_in))); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ab_held == '0 && ba_held == '0)); // R8
endmodule

bind duplex_hold_xcvr xcvr_checker #(.W(W)) u_xcvr_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .a_in        (a_in),
  .a_out       (a_out),
  .a_drive     (a_drive),
  .b_in        (b_in),
  .b_out       (b_out),
  .b_drive     (b_drive),
  .ab_oe_n     (ab_oe_n),
  .ab_pass     (ab_pass),
  .ab_stb_en_n (ab_stb_en_n),
  .ba_oe_n     (ba_oe_n),
  .ba_pass     (ba_pass),
  .ba_stb_en_n (ba_stb_en_n),
  .ab_held     (ab_held),
  .ba_held     (ba_held),
  .ab_rise     (ab_rise),
  .ba_rise     (ba_rise)
);

// File: tb/test_duplex_hold_xcvr.sv
`timescale 1ns/1ps
module test_duplex_hold_xcvr;
  localparam int unsigned W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_drive, b_drive;
  logic ab_oe_n = 1'b0, ab_pass = 1'b0, ab_stb = 1'b0, ab_stb_en_n = 1'b0;
  logic ba_oe_n = 1'b0, ba_pass = 1'b0, ba_stb = 1'b0, ba_stb_en_n = 1'b0;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  duplex_hold_xcvr #(.W(W)) i_duplex_hold_xcvr (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
    .ab_oe_n(ab_oe_n), .ab_pass(ab_pass), .ab_stb(ab_stb), .ab_stb_en_n(ab_stb_en_n),
    .ba_oe_n(ba_oe_n), .ba_pass(ba_pass), .ba_stb(ba_stb), .ba_stb_en_n(ba_stb_en_n)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // R8: strobes high through reset release must not capture.
  task automatic t_reset();
    a_in = 18'h15555; b_in = 18'h2AAAA;
    ab_stb = 1'b1; ba_stb = 1'b1;
    settle();
    chk("R8 reset b_out", b_out, '0);
    chk("R8 reset a_out", a_out, '0);
    step(); rst_n = 1'b1;
    step(); step();
    chk("R8 no edge at release b_out", b_out, '0);
    chk("R8 no edge at release a_out", a_out, '0);
    chk1("R8 drive on", b_drive, 1'b1);
    chk("R10 width", 18'(W), 18'(18));
    chk("R10 port width", 18'($bits(b_out)), 18'(18));
    ab_stb = 1'b0; ba_stb = 1'b0;
    step();
  endtask

  task automatic t_off();
    ab_oe_n = 1'b1; ba_oe_n = 1'b1; ab_pass = 1'b1; ba_pass = 1'b1;
    settle();
    chk1("R1 b_drive off", b_drive, 1'b0);
    chk("R1 b_out zero", b_out, '0);
    chk1("R1 a_drive off", a_drive, 1'b0);
    chk("R1 a_out zero", a_out, '0);
    ab_oe_n = 1'b0; ba_oe_n = 1'b0; ba_pass = 1'b0;
    settle();
    chk1("R1 b_drive back", b_drive, 1'b1);
  endtask

  task automatic t_pass();
    logic [W-1:0] pat [4] = '{18'h00000, 18'h3FFFF, 18'h0F0F0, 18'h31C47};
    ab_pass = 1'b1;
    for (int i = 0; i < 4; i++) begin
      a_in = pat[i];
      settle();
      chk("R2 transparent", b_out, pat[i]);
      step();
    end
  endtask

  task automatic t_pass_fall();
    a_in = 18'h12345; step();
    ab_pass = 1'b0; a_in = 18'h0BEEF; settle();
    chk("R6 value at pass fall", b_out, 18'h12345);
    step(); step();
    chk("R6 held after fall", b_out, 18'h12345);
  endtask

  task automatic t_capture();
    ab_stb_en_n = 1'b0; ab_stb = 1'b0; step();
    a_in = 18'h2D2D2; ab_stb = 1'b1; settle();
    chk("R3 before edge", b_out, 18'h12345);
    step();
    chk("R3 captured", b_out, 18'h2D2D2);
    a_in = 18'h11111; step(); step();
    chk("R5 strobe steady high", b_out, 18'h2D2D2);
    ab_stb = 1'b0; step(); step();
    chk("R5 strobe steady low", b_out, 18'h2D2D2);
  endtask

  task automatic t_enable();
    ab_stb_en_n = 1'b1; a_in = 18'h07777; step();
    ab_stb = 1'b1; step(); step();
    chk("R4 enable blocks", b_out, 18'h2D2D2);
    ab_stb = 1'b0; ab_stb_en_n = 1'b0; step();
  endtask

  task automatic t_oe_cycle();
    ab_oe_n = 1'b1; a_in = 18'h3A3A3; settle();
    chk("R1 disabled out", b_out, '0);
    step(); step(); step();
    ab_oe_n = 1'b0; settle();
    chk("R9 contents kept", b_out, 18'h2D2D2);
    chk1("R9 drive back", b_drive, 1'b1);
  endtask

  task automatic t_indep();
    ba_pass = 1'b1; b_in = 18'h0CAFE;
    a_in = 18'h1F00D; ab_stb = 1'b1; settle();
    chk("R7 ba transparent", a_out, 18'h0CAFE);
    step();
    chk("R7 ab captured", b_out, 18'h1F00D);
    chk("R7 ba unaffected", a_out, 18'h0CAFE);
    ba_pass = 1'b0; b_in = 18'h00001; ab_stb = 1'b0; step();
    a_in = 18'h2468A; ab_stb = 1'b1; step();
    chk("R7 ab second capture", b_out, 18'h2468A);
    chk("R7 ba held", a_out, 18'h0CAFE);
    ab_stb_en_n = 1'b1; ba_stb_en_n = 1'b0; ba_stb = 1'b1; step();
    chk("R3 ba capture", a_out, 18'h00001);
    chk("R7 ab unchanged", b_out, 18'h2468A);
    ba_oe_n = 1'b1; settle();
    chk1("R7 b_drive stays", b_drive, 1'b1);
    chk("R7 b_out stays", b_out, 18'h2468A);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_off();
    t_pass();
    t_pass_fall();
    t_capture();
    t_enable();
    t_oe_cycle();
    t_indep();
    step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule